// File: doc/BRIEF.md
# Protected On-Chip Static RAM Controller

This block sits between a simple synchronous bus and a 16 KB static RAM held as 4096 words of 32 bits. The RAM is divided into four 4 KB regions. Bus masters send one request at a time. Each request has a word address, a write enable and write data. It also carries a flag for instruction fetches and a flag for supervisor privilege. The controller answers each request with either an acknowledge or a transfer error. A separate register-select input points the request at the 32-bit configuration register instead of the RAM.

The configuration register has four kinds of control. A lock bit can be set once and freezes the register. A disable bit turns the RAM off. A mode bit chooses a two-clock access, where the first clock decodes the address and the second clock moves the data. Each region also has three attribute bits: read-only, data-only and supervisor-only. Every RAM access is checked against these settings in the same cycle its data would move. An access that breaks any rule gets one transfer-error pulse and does not complete. A blocked write leaves the RAM unchanged, and a blocked read returns zero.

While a two-clock access is in its decode clock, the block ignores new requests.

Top module: `sram_guard`

## Requirements
- R1: After reset the configuration register reads 0. At that point every RAM access by any privilege level, including an instruction fetch, is acknowledged in single-cycle timing.
- R2: The configuration bits use LSB-0 numbering. Bit 31 is the lock, bit 30 is disable and bit 29 is two-clock mode. Region k (k = 0..3) keeps its read-only, data-only and supervisor-only bits at positions 11-3k, 10-3k and 9-3k, so a register read returns them at those positions.
- R3: Bits 28 down to 12 always read as zero, whatever value is written to them.
- R4: Once the lock bit is set, every later write to the configuration register is acknowledged but changes nothing, until the next reset.
- R5: While the disable bit is set, every RAM read or write ends in a transfer error, and a blocked write leaves the RAM unchanged. The configuration register can still be accessed. Writing the disable bit back to 0 makes the RAM usable again, with its old contents.
- R6: In single-cycle mode, and for every configuration-register access in either mode, the response (acknowledge or transfer error) comes in the cycle right after the one in which the request is sampled.
- R7: In two-clock mode, a RAM access gives no response in the cycle after the request is sampled. Its response comes one cycle later.
- R8: A write to a region whose read-only bit is set raises a transfer error and leaves the RAM unchanged.
- R9: An instruction fetch from a region whose data-only bit is set raises a transfer error.
- R10: A user-privilege access (sup = 0) to a region whose supervisor-only bit is set raises a transfer error. A supervisor access to that region is allowed.
- R11: The region of an access is given by the top two bits of the word address. Attribute index 0 belongs to the lowest addresses and index 3 to the highest.
- R12: A failed access never asserts acknowledge. It asserts terr for exactly one cycle, once per access even when several rules are broken, and drives rdata to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, held high for one cycle per access |
| reg_sel | input | 1 | 1 selects the configuration register, 0 selects the RAM |
| addr | input | 12 | RAM word address; the top two bits select the region |
| we | input | 1 | 1 = write, 0 = read |
| ifetch | input | 1 | The read is an instruction fetch |
| sup | input | 1 | Supervisor privilege |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; zero on writes and on errors |
| ack | output | 1 | Access completed |
| terr | output | 1 | Access refused |

## Verification
Register accesses, and RAM accesses in single-cycle mode, must answer one clock edge after the request is sampled. The bench drives each request on a falling edge and samples ack, terr and rdata on the next falling edge. In two-clock mode the bench first checks that both response lines are still low at that falling edge, then samples the response one falling edge later. A blocked write is checked by reading the same word back later, through an unrestricted access, and comparing it with the bench's shadow copy of the RAM.

// File: rtl/sram_guard_pkg.sv
// Package sram_guard_pkg
// Shared constants for the protected SRAM controller: the configuration
// register width and the positions of its global control bits.
// Assumes LSB-0 numbering of the 32-bit configuration word.
package sram_guard_pkg;
    localparam int CFG_W    = 32;
    localparam int LOCK_BIT = 31;
    localparam int DIS_BIT  = 30;
    localparam int TWO_BIT  = 29;
    localparam int ATTR_PER_REGION = 3;
endpackage

// File: rtl/sram_guard_cfg.sv
// Module sram_guard_cfg
// Holds the configuration register. The lock bit can be set once and is
// cleared only by reset. Reserved bits are masked to zero on every write.
// Region attributes are unpacked as {read_only, data_only, sup_only},
// with region 0 taken from the most significant attribute triplet.
// Assumes 3*REGIONS <= 29.
module sram_guard_cfg
    import sram_guard_pkg::*;
#(
    parameter int REGIONS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [CFG_W-1:0]            wdata,
    output logic [CFG_W-1:0]            cfg_q,
    output logic                        disabled,
    output logic                        two_cycle,
    output logic [3*REGIONS-1:0]        attrs
);
    localparam int ATTR_W = ATTR_PER_REGION * REGIONS;
    localparam logic [CFG_W-1:0] KEEP =
        {3'b111, {(CFG_W-3-ATTR_W){1'b0}}, {ATTR_W{1'b1}}};

    // Register update: takes writes only while unlocked, and masks reserved bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && !cfg_q[LOCK_BIT]) begin
            cfg_q <= wdata & KEEP;
        end
    end

    assign disabled  = cfg_q[DIS_BIT];
    assign two_cycle = cfg_q[TWO_BIT];

    // Per-region attribute extraction: region k reads triplet REGIONS-1-k
    for (genvar k = 0; k < REGIONS; k++) begin : g_attr
        assign attrs[ATTR_PER_REGION*k +: ATTR_PER_REGION] =
            cfg_q[ATTR_PER_REGION*(REGIONS-1-k) +: ATTR_PER_REGION];
    end
endmodule

// File: rtl/sram_guard_check.sv
// Module sram_guard_check
// Purely combinational protection check for a single RAM access. The
// result is one error flag for all rules together. Assumes REGIONS >= 2
// and that attrs packs each region as {read_only, data_only, sup_only}.
module sram_guard_check #(
    parameter int REGIONS = 4,
    localparam int SEL_W = $clog2(REGIONS)
) (
    input  logic [SEL_W-1:0]     region,
    input  logic [3*REGIONS-1:0] attrs,
    input  logic                 disabled,
    input  logic                 we,
    input  logic                 ifetch,
    input  logic                 sup,
    output logic                 err
);
    logic [REGIONS-1:0] viol;

    // Per-region rule evaluation, gated by region decode
    for (genvar k = 0; k < REGIONS; k++) begin : g_rule
        logic ro, dataonly, suponly;
        assign ro       = attrs[3*k+2];
        assign dataonly = attrs[3*k+1];
        assign suponly  = attrs[3*k];
        assign viol[k]  = (region == SEL_W'(k)) &&
                          ((we && ro) || (ifetch && dataonly) || (!sup && suponly));
    end

    // Merge all reasons into a single error
    assign err = disabled || (|viol);
endmodule

// File: rtl/sram_guard_array.sv
// Module sram_guard_array
// Behavioural word array with a synchronous write port and an
// asynchronous read port. It has no reset, so contents are undefined
// until they are written.
module sram_guard_array #(
    parameter int WAW    = 12,
    parameter int DATA_W = 32,
    localparam int WORDS = 1 << WAW
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WAW-1:0]    addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Write port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    // Read port
    assign rdata = mem[addr];
endmodule

// File: rtl/sram_guard.sv
// Module sram_guard (top)
// Bus front end of the protected SRAM. It takes one request at a time.
// In single-cycle mode, and for every register access, the response
// appears one clock edge after the request is sampled. In two-clock mode
// a RAM request is latched on its first edge and completes on the second;
// requests that arrive during that decode cycle are ignored. Protection is
// evaluated on the completing edge using the configuration in force then.
module sram_guard
    import sram_guard_pkg::*;
#(
    parameter int REGIONS    = 4,
    parameter int REGION_WAW = 10,
    localparam int SEL_W     = $clog2(REGIONS),
    localparam int WAW       = REGION_WAW + SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             reg_sel,
    input  logic [WAW-1:0]   addr,
    input  logic             we,
    input  logic             ifetch,
    input  logic             sup,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic             ack,
    output logic             terr
);
    logic [CFG_W-1:0]     cfg_q;
    logic                 disabled, two_cycle;
    logic [3*REGIONS-1:0] attrs;

    logic                 busy;
    logic [WAW-1:0]       p_addr;
    logic                 p_we, p_if, p_sup;
    logic [CFG_W-1:0]     p_wdata;

    logic                 new_req, start_two, go;
    logic                 a_reg, a_we, a_if, a_sup;
    logic [WAW-1:0]       a_addr;
    logic [CFG_W-1:0]     a_wdata, mem_rd;
    logic                 chk_err, cfg_wr, mem_wr;

    // Request steering: decide whether this edge starts, or completes, an access
    assign new_req   = req && !busy;
    assign start_two = new_req && !reg_sel && two_cycle;
    assign go        = (new_req && !start_two) || busy;

    // Operand select: the latched request while completing, otherwise the bus
    assign a_reg   = busy ? 1'b0    : reg_sel;
    assign a_addr  = busy ? p_addr  : addr;
    assign a_we    = busy ? p_we    : we;
    assign a_if    = busy ? p_if    : ifetch;
    assign a_sup   = busy ? p_sup   : sup;
    assign a_wdata = busy ? p_wdata : wdata;

    assign cfg_wr = go && a_reg && a_we;
    assign mem_wr = go && !a_reg && a_we && !chk_err;

    sram_guard_cfg #(.REGIONS(REGIONS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wdata     (a_wdata),
        .cfg_q     (cfg_q),
        .disabled  (disabled),
        .two_cycle (two_cycle),
        .attrs     (attrs)
    );

    sram_guard_check #(.REGIONS(REGIONS)) u_check (
        .region   (a_addr[WAW-1 -: SEL_W]),
        .attrs    (attrs),
        .disabled (disabled),
        .we       (a_we),
        .ifetch   (a_if),
        .sup      (a_sup),
        .err      (chk_err)
    );

    sram_guard_array #(.WAW(WAW), .DATA_W(CFG_W)) u_array (
        .clk   (clk),
        .wr_en (mem_wr),
        .addr  (a_addr),
        .wdata (a_wdata),
        .rdata (mem_rd)
    );

    // Decode stage: holds a two-clock RAM request for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            p_addr  <= '0;
            p_we    <= 1'b0;
            p_if    <= 1'b0;
            p_sup   <= 1'b0;
            p_wdata <= '0;
        end else begin
            busy <= start_two;
            if (start_two) begin
                p_addr  <= addr;
                p_we    <= we;
                p_if    <= ifetch;
                p_sup   <= sup;
                p_wdata <= wdata;
            end
        end
    end

    // Response register: acknowledge or error for one cycle, data zero unless a good read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            terr  <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= go && (a_reg || !chk_err);
            terr  <= go && !a_reg && chk_err;
            if (go && !a_we && a_reg)
                rdata <= cfg_q;
            else if (go && !a_we && !chk_err)
                rdata <= mem_rd;
            else
                rdata <= '0;
        end
    end
endmodule

// File: rtl/sram_guard_chk.sv
// Module sram_guard_chk
// Temporal checks on the controller, bound into every sram_guard instance.
module sram_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        reg_sel,
    input logic        busy,
    input logic        two_cycle,
    input logic [31:0] cfg_q,
    input logic [31:0] rdata,
    input logic        ack,
    input logic        terr
);
    // R12: acknowledge and error never coincide
    a_r12_ack_terr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && terr));

    // R12: error responses carry zero data
    a_r12_error_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        terr |-> rdata == 32'h0);

    // R3: reserved field stays zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[28:12] == 17'h0);

    // R4: once locked, the whole register is frozen
    a_r4_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[31] |=> (cfg_q[31] && $stable(cfg_q)));

    // R6: single-cycle and register accesses answer on the next edge
    a_r6_single_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && (reg_sel || !two_cycle)) |=> (ack || terr));

    // R7: two-clock RAM accesses stay silent one cycle, then answer
    a_r7_two_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy && !reg_sel && two_cycle) |=> (!(ack || terr)) ##1 (ack || terr));
endmodule

bind sram_guard sram_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .reg_sel   (reg_sel),
    .busy      (busy),
    .two_cycle (two_cycle),
    .cfg_q     (cfg_q),
    .rdata     (rdata),
    .ack       (ack),
    .terr      (terr)
);

// File: tb/sram_guard_test.sv
// Bench for sram_guard: sweeps attribute patterns over every region and
// access kind in both timing modes, and keeps a shadow copy of the RAM.
module sram_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, reg_sel = 1'b0, we = 1'b0, ifetch = 1'b0, sup = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack, terr;

    int vectors = 0;
    int errs = 0;
    bit done = 0;
    logic [31:0] shadow [4096];

    always #2 clk = ~clk;

    sram_guard uut (
        .clk(clk), .rst_n(rst_n), .req(req), .reg_sel(reg_sel), .addr(addr),
        .we(we), .ifetch(ifetch), .sup(sup), .wdata(wdata),
        .rdata(rdata), .ack(ack), .terr(terr)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; the response is sampled one or two falling edges later
    task automatic access(input logic rs, input logic w, input logic f, input logic s,
                          input logic [11:0] a, input logic [31:0] d, input bit slow,
                          output logic g_ack, output logic g_terr, output logic [31:0] g_rd);
        @(negedge clk);
        req = 1'b1; reg_sel = rs; we = w; ifetch = f; sup = s; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0; ifetch = 1'b0; reg_sel = 1'b0;
        if (slow) begin
            check(!(ack || terr), "R7 early response", {30'h0, ack, terr}, 32'h0);
            @(negedge clk);
        end
        g_ack = ack; g_terr = terr; g_rd = rdata;
    endtask

    task automatic cfg_write(input logic [31:0] v);
        logic ga, gt; logic [31:0] gr;
        access(1'b1, 1'b1, 1'b0, 1'b1, 12'h0, v, 1'b0, ga, gt, gr);
        check(ga && !gt, "R6 register write ack", {30'h0, ga, gt}, 32'h2);
    endtask

    task automatic cfg_read(input logic [31:0] exp, input string tag);
        logic ga, gt; logic [31:0] gr;
        access(1'b1, 1'b0, 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, ga, gt, gr);
        check(ga && gr == exp, tag, gr, exp);
    endtask

    initial begin
        logic ga, gt; logic [31:0] gr;
        repeat (3) @(negedge clk);
        // R1: quiet outputs right after reset
        check(!ack && !terr && rdata == 0, "R1 outputs in reset", {ack, terr, rdata[29:0]}, 32'h0);
        rst_n = 1'b1;
        cfg_read(32'h0, "R1 config after reset");

        // Fill every word under the reset configuration (R1: user access allowed)
        for (int i = 0; i < 4096; i++) begin
            shadow[i] = i * 32'h9E3779B1 + 32'h1234;
            access(1'b0, 1'b1, 1'b0, 1'b0, 12'(i), shadow[i], 1'b0, ga, gt, gr);
            if (!ga || gt) check(1'b0, "R1 reset-state write", {30'h0, ga, gt}, 32'h2);
        end
        vectors++;
        access(1'b0, 1'b0, 1'b1, 1'b0, 12'hC05, 32'h0, 1'b0, ga, gt, gr);
        check(ga && gr == shadow[12'hC05], "R1 user fetch unrestricted", gr, shadow[12'hC05]);

        // R3 and R2: reserved bits drop, attributes keep their positions
        cfg_write(32'h1FFF_FFFF);
        cfg_read(32'h0000_0FFF, "R3 reserved masked");
        cfg_write(32'h0000_0000);

        // Main sweep: both modes, 8 rotated attribute patterns, all regions and access kinds
        for (int mode = 0; mode < 2; mode++) begin
            for (int c = 0; c < 8; c++) begin
                logic [31:0] v;
                v = mode ? 32'h2000_0000 : 32'h0;
                for (int k = 0; k < 4; k++) v |= 32'((c + k) % 8) << (9 - 3 * k);
                cfg_write(v);
                cfg_read(v, "R2 layout readback");
                for (int k = 0; k < 4; k++) begin
                    for (int kind = 0; kind < 6; kind++) begin
                        logic w, f, s, ro, dn, so, err;
                        logic [11:0] a;
                        logic [31:0] d, exp_rd;
                        logic [2:0] at;
                        string tag;
                        at = 3'((c + k) % 8);
                        ro = at[2]; dn = at[1]; so = at[0];
                        s = kind[0];
                        w = (kind == 2 || kind == 3);
                        f = (kind >= 4);
                        a = 12'(k * 1024 + (c * 37 + kind * 5 + mode * 200) % 1024);
                        d = {8'(k), 8'(c), 8'(kind), 8'(mode)} ^ 32'hA5A5_0000;
                        err = (w && ro) || (f && dn) || (!s && so);
                        tag = $sformatf("R8/R9/R10/R11/R12 region %0d attr %0d kind %0d mode %0d", k, at, kind, mode);
                        if (!err && mode == 0) tag = {tag, " R6"};
                        access(1'b0, w, f, s, a, d, mode == 1, ga, gt, gr);
                        check(ga == !err && gt == err, tag, {30'h0, ga, gt}, {30'h0, !err, err});
                        exp_rd = (err || w) ? 32'h0 : shadow[a];
                        check(gr == exp_rd, {tag, " data"}, gr, exp_rd);
                        if (w && !err) shadow[a] = d;
                        @(negedge clk);
                        check(!terr && !ack, "R12 single pulse", {30'h0, ack, terr}, 32'h0);
                    end
                end
            end
        end

        // R8: blocked writes left memory untouched; verify the whole array
        cfg_write(32'h0);
        for (int i = 0; i < 4096; i++) begin
            access(1'b0, 1'b0, 1'b0, 1'b1, 12'(i), 32'h0, 1'b0, ga, gt, gr);
            if (!ga || gr != shadow[i]) check(1'b0, $sformatf("R8 memory word %0d", i), gr, shadow[i]);
        end
        vectors++;

        // R7: register access stays single-cycle in two-clock mode
        cfg_write(32'h2000_0000);
        cfg_read(32'h2000_0000, "R7 register access single-cycle in two-clock mode");

        // R5: disable blocks reads and writes, config still reachable
        cfg_write(32'h4000_0000);
        access(1'b0, 1'b0, 1'b0, 1'b1, 12'h100, 32'h0, 1'b0, ga, gt, gr);
        check(gt && !ga && gr == 0, "R5 read while disabled", {30'h0, ga, gt}, 32'h1);
        access(1'b0, 1'b1, 1'b0, 1'b1, 12'h100, 32'hDEAD_BEEF, 1'b0, ga, gt, gr);
        check(gt && !ga, "R5 write while disabled", {30'h0, ga, gt}, 32'h1);
        cfg_read(32'h4000_0000, "R5 register reachable while disabled");
        cfg_write(32'h6000_0000);
        access(1'b0, 1'b0, 1'b0, 1'b1, 12'h100, 32'h0, 1'b1, ga, gt, gr);
        check(gt && !ga, "R5 R7 disabled in two-clock mode", {30'h0, ga, gt}, 32'h1);
        cfg_write(32'h0);
        access(1'b0, 1'b0, 1'b0, 1'b0, 12'h100, 32'h0, 1'b0, ga, gt, gr);
        check(ga && gr == shadow[12'h100], "R5 re-enabled contents kept", gr, shadow[12'h100]);

        // R12: several broken rules still give one error
        cfg_write(32'h0000_0007);
        access(1'b0, 1'b1, 1'b0, 1'b0, 12'hC00, 32'h1, 1'b0, ga, gt, gr);
        check(gt && !ga && gr == 0, "R12 multiple violations", {30'h0, ga, gt}, 32'h1);
        @(negedge clk);
        check(!terr, "R12 single pulse", {31'h0, terr}, 32'h0);

        // R4: lock freezes the register until reset
        cfg_write(32'h8000_0001);
        cfg_read(32'h8000_0001, "R4 lock set");
        cfg_write(32'h0000_0000);
        cfg_read(32'h8000_0001, "R4 write ignored while locked");
        access(1'b0, 1'b0, 1'b0, 1'b0, 12'hC01, 32'h0, 1'b0, ga, gt, gr);
        check(gt, "R4 R10 locked attribute still enforced", {31'h0, gt}, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        cfg_read(32'h0, "R1 R4 lock cleared by reset");
        cfg_write(32'h0000_0924);
        cfg_read(32'h0000_0924, "R4 writable after reset");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++; errs++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end
endmodule